// File: doc/BRIEF.md
# Descriptor-Chained Bus-Master DMA Engine

This block moves disk data between a device word stream and system memory without processor involvement. Software builds a table of 8-byte region descriptors in memory and loads the table address. It then sets the start bit of a one-byte command register, with the direction bit choosing which way the data flows. The engine reads the descriptors one by one. For each descriptor it moves every word of the described region, and it stops after the region whose descriptor carries the end-of-table flag.

Software sees three registers on a simple write port: command, status and table pointer. The current values are always visible on plain output pins. A single memory port with a request/grant handshake serves both the descriptor fetches and the data moves. The device side has one valid/ready stream in each direction and an interrupt input. Status bits report that the engine is active, that a memory fault occurred, and that the device raised its interrupt. Software clears the fault and interrupt bits by writing ones to them.

Back-pressure rules: a word on `dev_tx_*` transfers on a cycle with valid and ready both high. While valid is high and ready is low, the engine holds valid and the data steady. A word on `dev_rx_*` transfers on a cycle with valid and ready both high. The engine may leave ready low for any number of cycles. A memory request stays high, with address, write flag and write data unchanged, until the cycle that `mem_gnt` is high. `mem_rdata` and `mem_err` are taken in that same cycle.

Top module: `prd_dma_engine`

## Requirements
- R1: The register write port decodes `reg_addr` 0 as command, 1 as status and 2 as table pointer. The command register keeps only bit 3 (direction) and bit 0 (start); its other bits read as zero. All registers are zero after reset.
- R2: A table-pointer write stores the written address with bits 2..0 forced to zero.
- R3: A command write with bit 0 set, while the stored start bit is 0, sets ACT (status bit 0) on the next cycle. On that same cycle the engine requests a read at the table pointer. A descriptor is two words. The word at +0 is the region base. The word at +4 holds the byte count in bits 15..0 and the end-of-table flag in bit 31.
- R4: With direction 1, device words from `dev_rx_*` are written, in arrival order, to consecutive word addresses starting at the region base. With direction 0, words are read from consecutive addresses starting at the base and presented in order on `dev_tx_*`.
- R5: A region holds count/4 words; the low two bits of the count and of the base are ignored. A value of 0 in count bits 15..2 means 65536 bytes.
- R6: The next descriptor is 8 bytes further on. Only address bits 15..0 advance, so the walk wraps inside the 64 KB window of the table pointer. When the last word of an end-of-table region completes, ACT clears and no further memory request is made.
- R7: A command write with bit 0 clear clears ACT on the next cycle. While ACT is 0 the engine drives no memory request, no `dev_tx_valid` and no `dev_rx_ready`.
- R8: Command writes with bit 0 set while the stored start bit is already 1 do not restart the walk and do not change the direction of the run in progress.
- R9: A grant with `mem_err` high sets ERR (status bit 1), clears ACT and ends the run.
- R10: `dev_irq` high in a cycle sets INT (status bit 2) on the next cycle, whether or not the engine is active. It does not change ACT.
- R11: A status write clears ERR where bit 1 is 1 and INT where bit 2 is 1. Zero bits leave the flags unchanged, and bit 0 is ignored. A set event in the same cycle wins over the clear.
- R12: A pending memory request keeps its address, write flag and data stable until granted. A pending `dev_tx` word keeps valid and data stable until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 command, 1 status, 2 table pointer |
| reg_wdata | input | 32 | Register write data |
| cmd_o | output | 8 | Command register value |
| status_o | output | 8 | Status: bit 0 ACT, bit 1 ERR, bit 2 INT |
| tbl_ptr_o | output | 32 | Descriptor table pointer |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Memory grant; completes the request |
| mem_err | input | 1 | Error response, valid with grant |
| mem_rdata | input | 32 | Read data, valid with grant |
| dev_rx_valid | input | 1 | Device word to memory is valid |
| dev_rx_ready | output | 1 | Engine accepts a device word |
| dev_rx_data | input | 32 | Device word to memory |
| dev_tx_valid | output | 1 | Word for the device is valid |
| dev_tx_ready | input | 1 | Device accepts the word |
| dev_tx_data | output | 32 | Word for the device |
| dev_irq | input | 1 | Device interrupt |

## Verification
The assertions assume that the memory side never grants without a request and that `mem_err` is only read in a grant cycle. They also assume that software holds a single register write per cycle and does not start the engine again until it has written a stop. The stimulus keeps to these rules: grant and error are derived from the live request, and every run is preceded by a stop write. The device source holds its word until it is taken. Grant, valid and ready are each drawn at random per cycle, so stalls on every handshake are exercised.

// File: rtl/prd_dma_pkg.sv
package prd_dma_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_DESC_BASE,
    S_DESC_LEN,
    S_MEM_OP,
    S_DEV_OP
  } walk_state_t;

  localparam logic [1:0] REG_CMD  = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_TBL  = 2'd2;

  localparam int CMD_START = 0;
  localparam int CMD_DIR   = 3;
  localparam int ST_ACT    = 0;
  localparam int ST_ERR    = 1;
  localparam int ST_INT    = 2;

  localparam int DESC_BYTES = 8;
endpackage

// File: rtl/prd_regs.sv
module prd_regs
  import prd_dma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              act_clr_i,
  input  logic              err_set_i,
  input  logic              irq_i,
  output logic              start_o,
  output logic              stop_o,
  output logic              dir_o,
  output logic [ADDR_W-1:0] tbl_ptr_o,
  output logic [7:0]        cmd_o,
  output logic [7:0]        status_o
);
  localparam int ALIGN_W = $clog2(DESC_BYTES);

  logic              run_q, dir_q, act_q, err_q, int_q;
  logic [ADDR_W-1:0] tbl_q;
  logic              cmd_wr, st_wr, tbl_wr;

  assign cmd_wr  = wr_en && (wr_addr == REG_CMD);
  assign st_wr   = wr_en && (wr_addr == REG_STAT);
  assign tbl_wr  = wr_en && (wr_addr == REG_TBL);

  assign start_o = cmd_wr && wr_data[CMD_START] && !run_q;
  assign stop_o  = cmd_wr && !wr_data[CMD_START];
  assign dir_o   = wr_data[CMD_DIR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      dir_q <= 1'b0;
      act_q <= 1'b0;
      err_q <= 1'b0;
      int_q <= 1'b0;
      tbl_q <= '0;
    end else begin
      if (cmd_wr) begin
        run_q <= wr_data[CMD_START];
        dir_q <= wr_data[CMD_DIR];
      end
      if (tbl_wr) tbl_q <= {wr_data[ADDR_W-1:ALIGN_W], ALIGN_W'(0)};
      if (start_o) act_q <= 1'b1;
      else if (stop_o || act_clr_i) act_q <= 1'b0;
      err_q <= err_set_i | (err_q & ~(st_wr & wr_data[ST_ERR]));
      int_q <= irq_i | (int_q & ~(st_wr & wr_data[ST_INT]));
    end
  end

  assign tbl_ptr_o = tbl_q;
  assign cmd_o     = {4'b0, dir_q, 2'b0, run_q};
  assign status_o  = {5'b0, int_q, err_q, act_q};

  // R9: a faulted transfer leaves ERR set and the engine inactive
  p_fault_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_set_i |=> (status_o[ST_ERR] && !status_o[ST_ACT]));

  // R10: the device interrupt is never lost
  p_irq_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_i |=> status_o[ST_INT]);

  // R11: writing zero to a flag keeps it
  p_zero_keeps_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && !wr_data[ST_ERR] && status_o[ST_ERR]) |=> status_o[ST_ERR]);
endmodule

// File: rtl/prd_walker.sv
module prd_walker
  import prd_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              dir_i,
  input  logic [ADDR_W-1:0] tbl_ptr_i,
  output logic              done_o,
  output logic              fault_o,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_err,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data
);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int BYTE_SH    = $clog2(WORD_BYTES);
  localparam int WC_W       = CNT_W - BYTE_SH + 1;
  localparam logic [WC_W-1:0] FULL_WORDS = WC_W'(1) << (CNT_W - BYTE_SH);

  walk_state_t       state;
  logic [ADDR_W-1:0] dptr, raddr, dptr_next;
  logic [WC_W-1:0]   words_left, len_words;
  logic              eot_q, dir_q, last_word, gnt_ok, region_end;
  logic [DATA_W-1:0] buf_q;
  logic [CNT_W-BYTE_SH-1:0] cnt_field;

  assign cnt_field = mem_rdata[CNT_W-1:BYTE_SH];
  assign len_words = (cnt_field == '0) ? FULL_WORDS : WC_W'(cnt_field);
  assign dptr_next = {dptr[ADDR_W-1:CNT_W], dptr[CNT_W-1:0] + CNT_W'(DESC_BYTES)};
  assign last_word = (words_left == WC_W'(1));

  always_comb begin
    mem_req  = (state == S_DESC_BASE) || (state == S_DESC_LEN) || (state == S_MEM_OP);
    mem_we   = (state == S_MEM_OP) && dir_q;
    unique case (state)
      S_DESC_BASE: mem_addr = dptr;
      S_DESC_LEN:  mem_addr = dptr | ADDR_W'(WORD_BYTES);
      default:     mem_addr = raddr;
    endcase
    mem_wdata = buf_q;
    rx_ready  = (state == S_DEV_OP) && dir_q;
    tx_valid  = (state == S_DEV_OP) && !dir_q;
    tx_data   = buf_q;
  end

  assign gnt_ok     = mem_req && mem_gnt && !mem_err;
  assign fault_o    = mem_req && mem_gnt && mem_err;
  assign region_end = last_word &&
                      (((state == S_MEM_OP) && dir_q && gnt_ok) ||
                       (tx_valid && tx_ready));
  assign done_o     = region_end && eot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      dptr       <= '0;
      raddr      <= '0;
      words_left <= '0;
      eot_q      <= 1'b0;
      dir_q      <= 1'b0;
      buf_q      <= '0;
    end else if (stop_i || fault_o) begin
      state <= S_IDLE;
    end else begin
      unique case (state)
        S_IDLE: if (start_i) begin
          state <= S_DESC_BASE;
          dptr  <= tbl_ptr_i;
          dir_q <= dir_i;
        end
        S_DESC_BASE: if (gnt_ok) begin
          raddr <= {mem_rdata[ADDR_W-1:BYTE_SH], BYTE_SH'(0)};
          state <= S_DESC_LEN;
        end
        S_DESC_LEN: if (gnt_ok) begin
          words_left <= len_words;
          eot_q      <= mem_rdata[DATA_W-1];
          state      <= dir_q ? S_DEV_OP : S_MEM_OP;
        end
        S_MEM_OP: if (gnt_ok) begin
          if (dir_q) begin
            raddr      <= raddr + ADDR_W'(WORD_BYTES);
            words_left <= words_left - WC_W'(1);
            if (last_word) begin
              state <= eot_q ? S_IDLE : S_DESC_BASE;
              dptr  <= dptr_next;
            end else begin
              state <= S_DEV_OP;
            end
          end else begin
            buf_q <= mem_rdata;
            state <= S_DEV_OP;
          end
        end
        S_DEV_OP: begin
          if (dir_q && rx_valid) begin
            buf_q <= rx_data;
            state <= S_MEM_OP;
          end else if (!dir_q && tx_ready) begin
            raddr      <= raddr + ADDR_W'(WORD_BYTES);
            words_left <= words_left - WC_W'(1);
            if (last_word) begin
              state <= eot_q ? S_IDLE : S_DESC_BASE;
              dptr  <= dptr_next;
            end else begin
              state <= S_MEM_OP;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R12: a waiting memory request is not altered
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && !stop_i) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R12: a word offered to the device waits unchanged
  p_tx_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !stop_i) |=> (tx_valid && $stable(tx_data)));
endmodule

// File: rtl/prd_dma_engine.sv
module prd_dma_engine
  import prd_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [7:0]        cmd_o,
  output logic [7:0]        status_o,
  output logic [ADDR_W-1:0] tbl_ptr_o,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_err,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              dev_rx_valid,
  output logic              dev_rx_ready,
  input  logic [DATA_W-1:0] dev_rx_data,
  output logic              dev_tx_valid,
  input  logic              dev_tx_ready,
  output logic [DATA_W-1:0] dev_tx_data,
  input  logic              dev_irq
);
  logic start_p, stop_p, dir_w, done_p, fault_p;

  prd_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_en), .wr_addr(reg_addr), .wr_data(reg_wdata),
    .act_clr_i(done_p | fault_p), .err_set_i(fault_p), .irq_i(dev_irq),
    .start_o(start_p), .stop_o(stop_p), .dir_o(dir_w),
    .tbl_ptr_o(tbl_ptr_o), .cmd_o(cmd_o), .status_o(status_o)
  );

  prd_walker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_walker (
    .clk(clk), .rst_n(rst_n),
    .start_i(start_p), .stop_i(stop_p), .dir_i(dir_w), .tbl_ptr_i(tbl_ptr_o),
    .done_o(done_p), .fault_o(fault_p),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .rx_valid(dev_rx_valid), .rx_ready(dev_rx_ready), .rx_data(dev_rx_data),
    .tx_valid(dev_tx_valid), .tx_ready(dev_tx_ready), .tx_data(dev_tx_data)
  );

  // R3: starting sets ACT and issues the first descriptor read at the pointer
  p_start_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == REG_CMD && reg_wdata[CMD_START] && !cmd_o[CMD_START])
      |=> (status_o[ST_ACT] && mem_req && !mem_we && mem_addr == $past(tbl_ptr_o)));

  // R7: nothing is offered on either side while inactive
  p_quiet_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !status_o[ST_ACT] |-> (!mem_req && !dev_tx_valid && !dev_rx_ready));
endmodule

// File: tb/prd_dma_engine_bench.sv
module prd_dma_engine_bench;
  localparam int WD_LIMIT = 190000;
  localparam logic [31:0] SRC_BASE = 32'hC0DE_0000;

  typedef struct {
    bit          we;
    logic [31:0] addr;
    logic [31:0] data;
  } op_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [7:0]  cmd_o, status_o;
  logic [31:0] tbl_ptr_o;
  logic        mem_req, mem_we, mem_gnt, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        dev_rx_valid, dev_rx_ready, dev_tx_valid, dev_tx_ready, dev_irq;
  logic [31:0] dev_rx_data, dev_tx_data;

  always #5 clk = ~clk;

  prd_dma_engine u_prd_dma_engine (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .cmd_o(cmd_o), .status_o(status_o), .tbl_ptr_o(tbl_ptr_o),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .dev_rx_valid(dev_rx_valid), .dev_rx_ready(dev_rx_ready), .dev_rx_data(dev_rx_data),
    .dev_tx_valid(dev_tx_valid), .dev_tx_ready(dev_tx_ready), .dev_tx_data(dev_tx_data),
    .dev_irq(dev_irq)
  );

  logic [31:0] mem_m [int unsigned];
  op_t         exp_mem[$];
  logic [31:0] exp_tx[$];
  int          n_chk = 0, n_err = 0, cyc = 0;
  bit          wd_hit = 0;
  bit          act_m = 0, err_m = 0, int_m = 0, run_m = 0;
  bit          irq_now = 0, rx_taken = 0;
  int          gnt_pct = 60, rx_pct = 60, tx_pct = 60;
  logic [31:0] err_addr = 32'hFFFF_FFF0;
  int unsigned src_k = 0, src_exp = 0;
  bit          p_req = 0, p_we = 0, p_tx = 0;
  logic [31:0] p_addr = 0, p_wd = 0, p_txd = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  // One clock: drive inputs, step the reference model for the coming edge, then compare.
  task automatic tick();
    bit  consumed, stop_now, start_now, err_hit, st_wr;
    op_t o;
    cyc++;
    if (cyc > WD_LIMIT && !wd_hit) begin
      wd_hit = 1;
      chk(1'b0, "R6 watchdog: run never finished", 32'(cyc), 32'(WD_LIMIT));
    end
    if (rx_taken) dev_rx_valid = 1'b0;
    rx_taken  = 0;
    mem_gnt   = mem_req && (($urandom % 100) < gnt_pct);
    mem_err   = mem_gnt && (mem_addr == err_addr);
    mem_rdata = (mem_gnt && !mem_we && mem_m.exists(mem_addr)) ? mem_m[mem_addr] : 32'h0;
    if (!dev_rx_valid) dev_rx_valid = (($urandom % 100) < rx_pct);
    dev_rx_data  = SRC_BASE + src_k;
    dev_tx_ready = (($urandom % 100) < tx_pct);
    dev_irq      = irq_now;

    consumed  = 0;
    err_hit   = 0;
    stop_now  = reg_wr_en && reg_addr == 2'd0 && !reg_wdata[0];
    start_now = reg_wr_en && reg_addr == 2'd0 && reg_wdata[0] && !run_m;
    st_wr     = reg_wr_en && reg_addr == 2'd1;
    if (reg_wr_en && reg_addr == 2'd0) run_m = reg_wdata[0];
    if (dev_rx_valid && dev_rx_ready) begin
      src_k++;
      rx_taken = 1;
    end
    if (stop_now) begin
      exp_mem.delete();
      exp_tx.delete();
      act_m = 0;
    end else begin
      if (start_now) act_m = 1;
      if (mem_req && mem_gnt) begin
        if (exp_mem.size() == 0) begin
          chk(1'b0, "R6 unexpected memory request", mem_addr, 32'h0);
        end else begin
          o = exp_mem.pop_front();
          chk(mem_addr == o.addr && mem_we == o.we, "R3 R4 R5 R6 memory address/direction",
              mem_addr, o.addr);
          if (o.we) chk(mem_wdata == o.data, "R4 memory write data", mem_wdata, o.data);
          consumed = 1;
        end
        if (mem_err) begin
          err_hit = 1;
          act_m   = 0;
          exp_mem.delete();
          exp_tx.delete();
        end else if (mem_we) begin
          mem_m[mem_addr] = mem_wdata;
        end
      end
      if (dev_tx_valid && dev_tx_ready) begin
        if (exp_tx.size() == 0) chk(1'b0, "R4 unexpected device word", dev_tx_data, 32'h0);
        else chk(dev_tx_data == exp_tx.pop_front(), "R4 device word order", dev_tx_data, 32'h0);
        consumed = 1;
      end
      if (consumed && !err_hit && exp_mem.size() == 0 && exp_tx.size() == 0) act_m = 0;
    end
    err_m = err_hit | (err_m & !(st_wr && reg_wdata[1]));
    int_m = dev_irq | (int_m & !(st_wr && reg_wdata[2]));
    p_req  = mem_req && !mem_gnt && !stop_now;
    p_addr = mem_addr; p_we = mem_we; p_wd = mem_wdata;
    p_tx   = dev_tx_valid && !dev_tx_ready && !stop_now;
    p_txd  = dev_tx_data;

    @(negedge clk);
    chk(status_o == {5'b0, int_m, err_m, act_m}, "R3 R6 R9 R10 R11 status flags",
        32'(status_o), 32'({5'b0, int_m, err_m, act_m}));
    if (!act_m)
      chk(!mem_req && !dev_tx_valid && !dev_rx_ready, "R7 engine quiet while inactive",
          32'({mem_req, dev_tx_valid, dev_rx_ready}), 32'h0);
    if (p_req)
      chk(mem_req && mem_addr == p_addr && mem_we == p_we && mem_wdata == p_wd,
          "R12 memory request held", mem_addr, p_addr);
    if (p_tx)
      chk(dev_tx_valid && dev_tx_data == p_txd, "R12 device word held", dev_tx_data, p_txd);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr_en = 1'b0; reg_wdata = 32'h0;
  endtask

  // Place one descriptor in memory and queue the traffic it must cause.
  task automatic add_desc(input logic [31:0] daddr, input logic [31:0] base,
                          input logic [15:0] cnt, input bit eot, input bit dir);
    int unsigned words;
    logic [31:0] a;
    mem_m[daddr]     = base;
    mem_m[daddr + 4] = {eot, 15'b0, cnt};
    exp_mem.push_back('{we: 1'b0, addr: daddr, data: 32'h0});
    exp_mem.push_back('{we: 1'b0, addr: daddr + 4, data: 32'h0});
    words = (cnt[15:2] == 0) ? 16384 : int'(cnt[15:2]);
    for (int i = 0; i < int'(words); i++) begin
      a = {base[31:2], 2'b00} + 32'(4 * i);
      if (dir) begin
        exp_mem.push_back('{we: 1'b1, addr: a, data: SRC_BASE + src_exp});
        src_exp++;
      end else begin
        if (!mem_m.exists(a)) mem_m[a] = a ^ 32'h5A5A_0000;
        exp_mem.push_back('{we: 1'b0, addr: a, data: 32'h0});
        exp_tx.push_back(mem_m[a]);
      end
    end
  endtask

  task automatic run_idle();
    while ((act_m || exp_mem.size() > 0 || exp_tx.size() > 0) && !wd_hit) tick();
    repeat (3) tick();
  endtask

  initial begin
    void'($urandom(32'd11));
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_addr = 2'd0; reg_wdata = 32'h0;
    mem_gnt = 1'b0; mem_err = 1'b0; mem_rdata = 32'h0;
    dev_rx_valid = 1'b0; dev_rx_data = 32'h0; dev_tx_ready = 1'b0; dev_irq = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(cmd_o == 8'h00, "R1 reset command", 32'(cmd_o), 32'h0);
    chk(status_o == 8'h00, "R1 reset status", 32'(status_o), 32'h0);
    chk(tbl_ptr_o == 32'h0, "R1 reset table pointer", tbl_ptr_o, 32'h0);
    chk(!mem_req && !dev_tx_valid && !dev_rx_ready, "R1 reset outputs idle",
        32'({mem_req, dev_tx_valid, dev_rx_ready}), 32'h0);

    // R1 command keeps only bits 3 and 0
    reg_write(2'd0, 32'hF6);
    chk(cmd_o == 8'h00, "R1 command masking", 32'(cmd_o), 32'h00);
    reg_write(2'd0, 32'hFE);
    chk(cmd_o == 8'h08, "R1 command masking", 32'(cmd_o), 32'h08);

    // R2 pointer alignment
    reg_write(2'd2, 32'h0000_1007);
    chk(tbl_ptr_o == 32'h0000_1000, "R2 table pointer aligned", tbl_ptr_o, 32'h1000);

    // Two-region run into memory; the second base is unaligned (R5)
    src_exp = src_k;
    add_desc(32'h1000, 32'h2000, 16'd12, 1'b0, 1'b1);
    add_desc(32'h1008, 32'h3002, 16'd8,  1'b1, 1'b1);
    reg_write(2'd0, 32'h09);
    repeat (5) tick();
    reg_write(2'd0, 32'h01);  // R8: no restart, direction kept
    chk(cmd_o == 8'h01, "R8 command value after rewrite", 32'(cmd_o), 32'h01);
    run_idle();
    chk(status_o[0] == 1'b0, "R6 ACT clear after end of table", 32'(status_o), 32'h0);
    chk(mem_m[32'h3004] == SRC_BASE + src_exp - 1, "R4 R5 last word of aligned region",
        mem_m[32'h3004], SRC_BASE + src_exp - 1);

    // R10 interrupt while idle, R11 write-one-to-clear
    irq_now = 1; tick(); irq_now = 0; tick();
    chk(status_o[2] == 1'b1, "R10 INT set by device interrupt", 32'(status_o), 32'h4);
    reg_write(2'd1, 32'h0);
    chk(status_o[2] == 1'b1, "R11 zero write keeps INT", 32'(status_o), 32'h4);
    reg_write(2'd1, 32'h5);
    chk(status_o == 8'h00, "R11 one clears INT, ACT bit ignored", 32'(status_o), 32'h0);

    // Memory to device run; interrupt mid-run leaves ACT set (R10)
    reg_write(2'd0, 32'h00);
    reg_write(2'd2, 32'h1100);
    add_desc(32'h1100, 32'h4000, 16'd16, 1'b1, 1'b0);
    reg_write(2'd0, 32'h01);
    repeat (4) tick();
    irq_now = 1; tick(); irq_now = 0;
    chk(status_o[0] == 1'b1 && status_o[2] == 1'b1, "R10 early interrupt keeps ACT",
        32'(status_o), 32'h5);
    run_idle();
    reg_write(2'd1, 32'h4);

    // R6 descriptor walk wraps inside the 64 KB window
    reg_write(2'd0, 32'h08);
    reg_write(2'd2, 32'h0001_FFF8);
    src_exp = src_k;
    add_desc(32'h0001_FFF8, 32'h5000, 16'd4, 1'b0, 1'b1);
    add_desc(32'h0001_0000, 32'h5100, 16'd8, 1'b1, 1'b1);
    reg_write(2'd0, 32'h09);
    run_idle();
    chk(mem_m[32'h5104] == SRC_BASE + src_exp - 1, "R6 wrapped descriptor used",
        mem_m[32'h5104], SRC_BASE + src_exp - 1);

    // R9 memory error during data reads
    reg_write(2'd0, 32'h00);
    reg_write(2'd2, 32'h1200);
    add_desc(32'h1200, 32'h6000, 16'd16, 1'b1, 1'b0);
    err_addr = 32'h6008;
    reg_write(2'd0, 32'h01);
    run_idle();
    err_addr = 32'hFFFF_FFF0;
    chk(status_o == 8'h02, "R9 ERR set and ACT clear", 32'(status_o), 32'h02);
    reg_write(2'd1, 32'h4);
    chk(status_o == 8'h02, "R11 clearing INT keeps ERR", 32'(status_o), 32'h02);
    reg_write(2'd1, 32'h2);
    chk(status_o == 8'h00, "R11 one clears ERR", 32'(status_o), 32'h0);
    irq_now = 1;
    reg_write(2'd1, 32'h4);
    irq_now = 0;
    chk(status_o[2] == 1'b1, "R11 set wins over clear", 32'(status_o), 32'h4);
    reg_write(2'd1, 32'h4);

    // R5 zero count means 64 KB
    reg_write(2'd0, 32'h08);
    reg_write(2'd2, 32'h1300);
    src_exp = src_k;
    gnt_pct = 80; rx_pct = 80;
    add_desc(32'h1300, 32'h0004_0000, 16'd0, 1'b1, 1'b1);
    reg_write(2'd0, 32'h09);
    run_idle();
    chk(mem_m.exists(32'h0004_FFFC) && mem_m[32'h0004_FFFC] == SRC_BASE + src_exp - 1,
        "R5 full 64 KB region", mem_m[32'h0004_FFFC], SRC_BASE + src_exp - 1);

    // R7 stop in the middle of a run
    reg_write(2'd0, 32'h00);
    reg_write(2'd2, 32'h1400);
    add_desc(32'h1400, 32'h0008_0000, 16'd0, 1'b1, 1'b0);
    reg_write(2'd0, 32'h01);
    repeat (40) tick();
    reg_write(2'd0, 32'h00);
    chk(status_o[0] == 1'b0, "R7 stop clears ACT", 32'(status_o), 32'h0);
    repeat (20) tick();
    chk(!mem_req, "R7 no request after stop", 32'(mem_req), 32'h0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule